// File: doc/BRIEF.md
# Reset Control I/O Port

This block is a one-byte register on the platform's I/O port space that software uses to ask for a platform reset. A byte written to the port with the trigger bit set raises a reset request toward the reset sequencer and changes nothing in the register. Any other byte written to the port is stored, but only its two reset-kind qualifier bits survive. Those bits tell the sequencer what kind of reset a later trigger means: bit 3 asks for a full reset and bit 1 asks for a system reset.

Reads of the port return the stored qualifier bits. A status output stays high while the stored byte is nonzero. A state-save agent uses it to decide whether the register has to be captured. The block decodes one I/O address, set by a parameter, and ignores accesses to every other address. The sequencing that follows a reset request is handled outside this block.

Top module: `rstctl_port`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the stored byte is 0x00, `io_rdata` is 0x00, `sys_rst_req` is low and `save_needed` is low. An assertion of `rst` at any later time clears a nonzero stored byte to 0x00.
- R2: A write to the decoded address with bit 2 of `io_wdata` set drives `sys_rst_req` high in exactly the next cycle, for one cycle per such write.
- R3: A write to the decoded address with bit 2 set leaves the stored byte unchanged.
- R4: A write to the decoded address with bit 2 clear stores `io_wdata & 0x0A`. Bit 3 is the full-reset qualifier and bit 1 is the system-reset qualifier. Bits 7:4, 2 and 0 always read back as zero.
- R5: A read strobe at the decoded address puts the stored byte on `io_rdata` in the next cycle. In every other cycle `io_rdata` is 0x00.
- R6: When a read and a write to the decoded address happen in the same cycle, the read returns the byte held before that write.
- R7: `save_needed` is high exactly while the stored byte is nonzero.
- R8: Writes and reads at any other address leave the stored byte unchanged and raise no reset request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Registered read data, valid the cycle after `io_rd` |
| sys_rst_req | output | 1 | One-cycle platform reset request |
| save_needed | output | 1 | High while the stored byte is nonzero |

## Verification
The bench writes bytes that have the trigger bit set together with qualifier bits. A design that stored such a byte, or stored it with the mask applied, reads back different qualifiers afterwards. All-ones and all-but-trigger patterns expose a wrong mask as stray bits 0 or 2 in the read data. A wrong mask also leaves `save_needed` high after a write of 0xF1, which should clear the register. Writes to a neighbouring address catch a decoder that drops an address bit, because such a design would either fire a request or overwrite the stored byte. A read issued in the same cycle as a write catches a design that forwards the new value. Two idle cycles after each trigger catch a request line that stays high.

// File: rtl/rstctl_pkg.sv
`timescale 1ns/1ps
package rstctl_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned TRIG_BIT = 2;
  localparam int unsigned FULL_BIT = 3;
  localparam int unsigned SYS_BIT  = 1;

  typedef logic [DATA_W-1:0] byte_t;

  localparam byte_t KEEP_MASK = byte_t'((1 << FULL_BIT) | (1 << SYS_BIT));
endpackage

// File: rtl/rstctl_decode.sv
`timescale 1ns/1ps
module rstctl_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic match;

  always_comb begin
    match  = (addr == PORT_ADDR);
    wr_hit = wr && match;
    rd_hit = rd && match;
  end
endmodule

// File: rtl/rstctl_store.sv
`timescale 1ns/1ps
module rstctl_store
  import rstctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  logic  rd_en,
  input  byte_t wdata,
  output byte_t val_q,
  output byte_t rdata_q
);
  logic take;

  always_comb take = wr_en && !wdata[TRIG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (take) val_q <= wdata & KEEP_MASK;
      rdata_q <= rd_en ? val_q : '0;
    end
  end

  // R3
  trig_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata[TRIG_BIT]) |=> $stable(val_q));

  // R8
  idle_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(val_q));

  // R4
  mask_only_chk: assert property (@(posedge clk) disable iff (rst)
    (val_q & ~KEEP_MASK) == '0);

  // R5
  read_value_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rdata_q == $past(val_q)));

  // R5
  read_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata_q == '0));
endmodule

// File: rtl/rstctl_pulse.sv
`timescale 1ns/1ps
module rstctl_pulse (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic trig,
  output logic req_q
);
  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= wr_en && trig;
  end

  // R2
  req_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && trig) |=> req_q);

  // R2
  req_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && trig) |=> !req_q);
endmodule

// File: rtl/rstctl_port.sv
`timescale 1ns/1ps
module rstctl_port
  import rstctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [DATA_W-1:0] io_rdata,
  output logic              sys_rst_req,
  output logic              save_needed
);
  logic  wr_hit;
  logic  rd_hit;
  byte_t val_q;
  byte_t rdata_q;
  logic  req_q;

  rstctl_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .addr   (io_addr),
    .wr     (io_wr),
    .rd     (io_rd),
    .wr_hit (wr_hit),
    .rd_hit (rd_hit)
  );

  rstctl_store u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_hit),
    .rd_en   (rd_hit),
    .wdata   (io_wdata),
    .val_q   (val_q),
    .rdata_q (rdata_q)
  );

  rstctl_pulse u_pulse (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_hit),
    .trig  (io_wdata[TRIG_BIT]),
    .req_q (req_q)
  );

  assign io_rdata    = rdata_q;
  assign sys_rst_req = req_q;
  assign save_needed = |val_q;

  // R8
  foreign_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr != PORT_ADDR) |=> !sys_rst_req);

  // R1
  reset_out_chk: assert property (@(posedge clk)
    rst |=> (io_rdata == '0 && !sys_rst_req && !save_needed));
endmodule

// File: tb/rstctl_port_test.sv
`timescale 1ns/1ps
module rstctl_port_test;
  localparam logic [15:0] PA = 16'h0CF9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic        sys_rst_req;
  logic        save_needed;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rstctl_port #(.ADDR_W(16), .PORT_ADDR(PA)) uut (
    .clk         (clk),
    .rst         (rst),
    .io_addr     (io_addr),
    .io_wdata    (io_wdata),
    .io_wr       (io_wr),
    .io_rd       (io_rd),
    .io_rdata    (io_rdata),
    .sys_rst_req (sys_rst_req),
    .save_needed (save_needed)
  );

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  // write; returns sampled request on the cycle after the strobe
  task automatic wr_port(input logic [15:0] a, input logic [7:0] d, output logic req);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    req = sys_rst_req;
    io_wr = 1'b0;
  endtask

  task automatic rd_port(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 rdata", io_rdata, 0);
    check("R1 req", sys_rst_req, 0);
    check("R1 save", save_needed, 0);
    rd_port(PA, d);
    check("R1 stored", d, 0);
  endtask

  task automatic t_mask();
    logic r; logic [7:0] d;
    wr_port(PA, 8'hFB, r);
    check("R4 no req", r, 0);
    rd_port(PA, d);
    check("R4 mask FB", d, 8'h0A);
    check("R7 save hi", save_needed, 1);
    wr_port(PA, 8'h09, r);
    rd_port(PA, d);
    check("R4 full bit", d, 8'h08);
    wr_port(PA, 8'h03, r);
    rd_port(PA, d);
    check("R4 sys bit", d, 8'h02);
    wr_port(PA, 8'hF1, r);
    rd_port(PA, d);
    check("R4 clear", d, 8'h00);
    check("R7 save lo", save_needed, 0);
  endtask

  task automatic t_trigger();
    logic r; logic [7:0] d;
    wr_port(PA, 8'h08, r);
    wr_port(PA, 8'h04, r);
    check("R2 req fires", r, 1);
    @(negedge clk);
    check("R2 one cycle", sys_rst_req, 0);
    rd_port(PA, d);
    check("R3 kept after 04", d, 8'h08);
    wr_port(PA, 8'hFF, r);
    check("R2 req FF", r, 1);
    @(negedge clk);
    check("R2 drop FF", sys_rst_req, 0);
    rd_port(PA, d);
    check("R3 kept after FF", d, 8'h08);
    check("R7 save kept", save_needed, 1);
  endtask

  task automatic t_foreign();
    logic r; logic [7:0] d;
    wr_port(PA ^ 16'h0001, 8'h02, r);
    check("R8 no req store", r, 0);
    wr_port(PA ^ 16'h0100, 8'h04, r);
    check("R8 no req trig", r, 0);
    rd_port(PA, d);
    check("R8 stored intact", d, 8'h08);
    rd_port(PA ^ 16'h0001, d);
    check("R5 foreign read", d, 0);
    @(negedge clk);
    check("R5 idle rdata", io_rdata, 0);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    @(negedge clk);
    io_addr = PA; io_wdata = 8'h02; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk);
    check("R6 old value", io_rdata, 8'h08);
    io_wr = 1'b0; io_rd = 1'b0;
    rd_port(PA, d);
    check("R6 new value", d, 8'h02);
  endtask

  task automatic t_reset_clear();
    logic r; logic [7:0] d;
    wr_port(PA, 8'h0A, r);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 save cleared", save_needed, 0);
    rd_port(PA, d);
    check("R1 value cleared", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mask();
    t_trigger();
    t_foreign();
    t_same_cycle();
    t_reset_clear();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=0x0 exp=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule